// File: doc/BRIEF.md
# Hamming-protected flit storage path

This block guards the payload of each flit while it waits in router queues. On the write side, a flit entering a queue is expanded into a single-error-correcting Hamming codeword, and the codeword is what gets stored. On the read side, at the last stage before the output link, a codeword taken from the queue is checked. A single flipped bit is put right before the flit leaves the router.

Both directions are one registered stage with a valid qualifier and no handshake back-pressure. A valid input in every cycle produces a valid output in every cycle, with no gaps. The data width is a parameter. The parity count is the smallest p with 2^p >= m + p + 1, so 8, 16 and 32-bit flits take 4, 5 and 6 parity bits. The read side reports the corrected data, the raw syndrome, a flag that a mismatch was seen, and a flag for syndromes that point past the end of the codeword. Reset is asynchronous active-low. Its release passes through a two-stage synchroniser.

Top module: `ecc_flit_path`

## Requirements
- R1: With DATA_W = 8, the codeword has 12 bits, made of 8 data bits and 4 parity bits, the minimum p that meets 2^p >= m + p + 1.
- R2: Codeword bit index i holds position i+1. Parity bits occupy positions 1, 2, 4 and 8 (bit indices 0, 1, 3, 7). Data bit j (wr_data[j], called d(j+1)) fills the remaining positions in ascending order: d1 at position 3 and d8 at position 12. For example, data 8'h01 encodes to 12'h007 and data 8'h80 encodes to 12'h888.
- R3: Parity at position 2^k is the XOR of every data position whose 1-based index has bit k set. Thus p1 = d1^d2^d4^d5^d7, p2 = d1^d3^d4^d6^d7, p4 = d2^d3^d4^d8 and p8 = d5^d6^d7^d8.
- R4: enc_valid and enc_code follow wr_valid and wr_data by exactly one clock. Back-to-back inputs give back-to-back outputs.
- R5: In a cycle after wr_valid was low, enc_valid is low and enc_code keeps its previous value.
- R6: out_syndrome is one clock after rd_valid. Bit k of out_syndrome is the XOR of all codeword positions whose index has bit k set, so {c8,c4,c2,c1} reads out a 1-based position.
- R7: A zero syndrome passes the stored data bits through unchanged, with out_err and out_uncorr both low.
- R8: A syndrome s in 1..CODE_W flips codeword position s before the data bits are extracted. out_err is high and out_uncorr is low. Any single-bit corruption of a valid codeword is therefore fully corrected.
- R9: A syndrome above CODE_W (13..15 for 8-bit data) raises both out_err and out_uncorr. The data bits are then passed out without any flip.
- R10: out_valid follows rd_valid by one clock with no bubbles. When rd_valid was low, out_valid is low and out_data, out_syndrome, out_err and out_uncorr hold.
- R11: While rst_n is low, and until its synchronised release, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Flit presented for encoding |
| wr_data | input | DATA_W | Flit payload to protect |
| enc_valid | output | 1 | Codeword ready for the queue |
| enc_code | output | CODE_W | Encoded codeword |
| rd_valid | input | 1 | Codeword read from the queue |
| rd_code | input | CODE_W | Stored codeword, possibly corrupted |
| out_valid | output | 1 | Checked flit ready for the output link |
| out_data | output | DATA_W | Corrected payload |
| out_syndrome | output | PAR_W | Check bits {c(2^(p-1))..c2,c1} |
| out_err | output | 1 | Syndrome was non-zero |
| out_uncorr | output | 1 | Syndrome pointed beyond the codeword |

## Verification
Each side's results are due exactly one clock after its inputs. The codeword is due on the edge after wr_valid, and the data, syndrome and flags are due on the edge after rd_valid. The bench drives on a falling edge and, at the next falling edge, compares the values that rising edge produced before it drives the following vector. Streams therefore run back to back, and idle cycles fall between them to expose the hold behaviour. The sweep covers every 8-bit payload through the encoder, and every payload decoded clean and with each of the 12 single flips. Every double flip is also applied, which reaches the miscorrected and out-of-range syndromes.

// File: rtl/ecc_flit_pkg.sv
package ecc_flit_pkg;

  // Smallest parity count p meeting 2^p >= m + p + 1.
  function automatic int par_w_f(input int m);
    int p;
    p = 1;
    while ((1 << p) < (m + p + 1)) p++;
    return p;
  endfunction

endpackage

// File: rtl/ecc_flit_rst_sync.sv
module ecc_flit_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/ecc_flit_scatter.sv
// Places data bits at the non-power-of-two positions; parity slots are zero.
module ecc_flit_scatter #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] word
);

  for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_pos
    if ((pos & (pos - 1)) == 0) begin : g_par
      assign word[pos-1] = 1'b0;
    end else begin : g_dat
      assign word[pos-1] = data[pos - $clog2(pos + 1) - 1];
    end
  end

endmodule

// File: rtl/ecc_flit_gather.sv
// Extracts data bits from the non-power-of-two positions of a codeword.
module ecc_flit_gather #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic [CODE_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic              unused_par
);

  logic [CODE_W-1:0] par_bits;

  for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_pos
    if ((pos & (pos - 1)) == 0) begin : g_par
      assign par_bits[pos-1] = word[pos-1];
    end else begin : g_dat
      assign par_bits[pos-1] = 1'b0;
      assign data[pos - $clog2(pos + 1) - 1] = word[pos-1];
    end
  end

  assign unused_par = ^par_bits;

endmodule

// File: rtl/ecc_flit_tree.sv
// Check-bit XOR trees; bit k covers every position whose index has bit k set.
module ecc_flit_tree #(
  parameter int CODE_W = 12,
  parameter int PAR_W  = 4
) (
  input  logic [CODE_W-1:0] word,
  output logic [PAR_W-1:0]  chk
);

  for (genvar k = 0; k < PAR_W; k++) begin : g_chk
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int pos = 1; pos <= CODE_W; pos++) begin
        if (((pos >> k) & 1) != 0) acc = acc ^ word[pos-1];
      end
    end
    assign chk[k] = acc;
  end

endmodule

// File: rtl/ecc_flit_enc.sv
module ecc_flit_enc #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              cw_valid,
  output logic [CODE_W-1:0] cw_code
);

  logic [CODE_W-1:0] placed;
  logic [PAR_W-1:0]  par;
  logic [CODE_W-1:0] code_next;
  logic [CODE_W-1:0] code_d;

  ecc_flit_scatter #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_scatter (
    .data (in_data),
    .word (placed)
  );

  ecc_flit_tree #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_tree (
    .word (placed),
    .chk  (par)
  );

  always_comb begin
    code_next = placed;
    for (int k = 0; k < PAR_W; k++) code_next[(1 << k) - 1] = par[k];
  end

  always_comb begin
    code_d = in_valid ? code_next : cw_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cw_valid <= 1'b0;
      cw_code  <= '0;
    end else begin
      cw_valid <= in_valid;
      cw_code  <= code_d;
    end
  end

endmodule

// File: rtl/ecc_flit_dec.sv
module ecc_flit_dec #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              fx_valid,
  output logic [DATA_W-1:0] fx_data,
  output logic [PAR_W-1:0]  fx_syn,
  output logic              fx_err,
  output logic              fx_uncorr
);

  logic [PAR_W-1:0]  syn;
  logic [CODE_W-1:0] flip;
  logic [CODE_W-1:0] fixed;
  logic [DATA_W-1:0] data_next;
  logic              unused_par;
  logic              err_next;
  logic              uncorr_next;

  logic [DATA_W-1:0] data_d;
  logic [PAR_W-1:0]  syn_d;
  logic              err_d;
  logic              uncorr_d;

  ecc_flit_tree #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_tree (
    .word (in_code),
    .chk  (syn)
  );

  for (genvar pos = 1; pos <= CODE_W; pos++) begin : g_flip
    assign flip[pos-1] = (syn == PAR_W'(pos));
  end

  assign fixed = in_code ^ flip;

  ecc_flit_gather #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_gather (
    .word       (fixed),
    .data       (data_next),
    .unused_par (unused_par)
  );

  assign err_next    = |syn;
  assign uncorr_next = (syn > PAR_W'(CODE_W));

  always_comb begin
    if (in_valid) begin
      data_d   = data_next;
      syn_d    = syn;
      err_d    = err_next;
      uncorr_d = uncorr_next;
    end else begin
      data_d   = fx_data;
      syn_d    = fx_syn;
      err_d    = fx_err;
      uncorr_d = fx_uncorr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fx_valid  <= 1'b0;
      fx_data   <= '0;
      fx_syn    <= '0;
      fx_err    <= 1'b0;
      fx_uncorr <= 1'b0;
    end else begin
      fx_valid  <= in_valid;
      fx_data   <= data_d;
      fx_syn    <= syn_d;
      fx_err    <= err_d;
      fx_uncorr <= uncorr_d;
    end
  end

endmodule

// File: rtl/ecc_flit_path.sv
module ecc_flit_path
  import ecc_flit_pkg::*;
#(
  parameter  int DATA_W = 8,
  localparam int PAR_W  = par_w_f(DATA_W),
  localparam int CODE_W = DATA_W + PAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enc_valid,
  output logic [CODE_W-1:0] enc_code,
  input  logic              rd_valid,
  input  logic [CODE_W-1:0] rd_code,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic [PAR_W-1:0]  out_syndrome,
  output logic              out_err,
  output logic              out_uncorr
);

  logic rst_sync_n;

  ecc_flit_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ecc_flit_enc #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (wr_valid),
    .in_data  (wr_data),
    .cw_valid (enc_valid),
    .cw_code  (enc_code)
  );

  ecc_flit_dec #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .in_valid  (rd_valid),
    .in_code   (rd_code),
    .fx_valid  (out_valid),
    .fx_data   (out_data),
    .fx_syn    (out_syndrome),
    .fx_err    (out_err),
    .fx_uncorr (out_uncorr)
  );

endmodule

// File: rtl/ecc_flit_path_chk.sv
module ecc_flit_path_chk #(
  parameter int DATA_W = 8,
  parameter int PAR_W  = 4,
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [DATA_W-1:0] wr_data,
  input logic              enc_valid,
  input logic [CODE_W-1:0] enc_code,
  input logic              rd_valid,
  input logic [CODE_W-1:0] rd_code,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic [PAR_W-1:0]  out_syndrome,
  input logic              out_err,
  input logic              out_uncorr
);

  function automatic logic [DATA_W-1:0] pick_data(input logic [CODE_W-1:0] w);
    logic [DATA_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int pos = 1; pos <= CODE_W; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        d[j] = w[pos-1];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [PAR_W-1:0] check_bits(input logic [CODE_W-1:0] w);
    logic [PAR_W-1:0] s;
    s = '0;
    for (int pos = 1; pos <= CODE_W; pos++) begin
      for (int k = 0; k < PAR_W; k++) begin
        if (((pos >> k) & 1) != 0) s[k] = s[k] ^ w[pos-1];
      end
    end
    return s;
  endfunction

  assert_enc_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> enc_valid);

  assert_enc_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!enc_valid && $stable(enc_code)));

  assert_enc_payload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> (pick_data(enc_code) == $past(wr_data)));

  assert_enc_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid |-> (check_bits(enc_code) == '0));

  assert_dec_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> out_valid);

  assert_dec_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!out_valid && $stable(out_data) && $stable(out_syndrome)));

  assert_dec_syndrome_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> (out_syndrome == check_bits($past(rd_code))));

  assert_dec_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && (check_bits(rd_code) == '0)) |=>
      (!out_err && !out_uncorr && (out_data == pick_data($past(rd_code)))));

  assert_dec_uncorr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncorr |-> out_err);

endmodule

bind ecc_flit_path ecc_flit_path_chk #(
  .DATA_W (DATA_W),
  .PAR_W  (PAR_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_valid     (wr_valid),
  .wr_data      (wr_data),
  .enc_valid    (enc_valid),
  .enc_code     (enc_code),
  .rd_valid     (rd_valid),
  .rd_code      (rd_code),
  .out_valid    (out_valid),
  .out_data     (out_data),
  .out_syndrome (out_syndrome),
  .out_err      (out_err),
  .out_uncorr   (out_uncorr)
);

// File: tb/ecc_flit_path_test.sv
`timescale 1ns/1ps
module ecc_flit_path_test;

  logic        clk;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_data;
  logic        enc_valid;
  logic [11:0] enc_code;
  logic        rd_valid;
  logic [11:0] rd_code;
  logic        out_valid;
  logic [7:0]  out_data;
  logic [3:0]  out_syndrome;
  logic        out_err;
  logic        out_uncorr;

  int checks;
  int errors;
  bit done;

  ecc_flit_path #(.DATA_W(8)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_data      (wr_data),
    .enc_valid    (enc_valid),
    .enc_code     (enc_code),
    .rd_valid     (rd_valid),
    .rd_code      (rd_code),
    .out_valid    (out_valid),
    .out_data     (out_data),
    .out_syndrome (out_syndrome),
    .out_err      (out_err),
    .out_uncorr   (out_uncorr)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Bench model, written from R2/R3/R6..R9.
  function automatic logic [11:0] m_encode(input logic [7:0] d);
    logic [11:0] w;
    int j;
    w = '0;
    j = 0;
    for (int pos = 1; pos <= 12; pos++) begin
      if (pos != 1 && pos != 2 && pos != 4 && pos != 8) begin
        w[pos-1] = d[j];
        j++;
      end
    end
    for (int k = 0; k < 4; k++) begin
      logic p;
      p = 1'b0;
      for (int pos = 1; pos <= 12; pos++)
        if ((pos / (1 << k)) % 2 == 1 && pos != (1 << k)) p = p ^ w[pos-1];
      w[(1 << k) - 1] = p;
    end
    return w;
  endfunction

  function automatic logic [3:0] m_syn(input logic [11:0] w);
    logic [3:0] s;
    s = '0;
    for (int k = 0; k < 4; k++)
      for (int pos = 1; pos <= 12; pos++)
        if ((pos / (1 << k)) % 2 == 1) s[k] = s[k] ^ w[pos-1];
    return s;
  endfunction

  function automatic logic [7:0] m_data(input logic [11:0] w);
    logic [7:0] d;
    int j;
    d = '0;
    j = 0;
    for (int pos = 1; pos <= 12; pos++) begin
      if (pos != 1 && pos != 2 && pos != 4 && pos != 8) begin
        d[j] = w[pos-1];
        j++;
      end
    end
    return d;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expectations for the outputs after the next rising edge.
  logic        x_ev;
  logic [11:0] x_ec;
  logic        x_ov;
  logic [7:0]  x_od;
  logic [3:0]  x_os;
  logic        x_oe;
  logic        x_ou;
  string       x_tag;

  task automatic step(input logic wv, input logic [7:0] wd,
                      input logic rv, input logic [11:0] rc);
    logic [3:0]  s;
    logic [11:0] fixed;
    @(negedge clk);
    // outputs produced by the edge that just passed
    check(enc_valid == x_ev, x_ev ? "R4" : "R5", "enc_valid", enc_valid, x_ev);
    check(enc_code == x_ec, x_ev ? "R3" : "R5", "enc_code", enc_code, x_ec);
    check(out_valid == x_ov, "R10", "out_valid", out_valid, x_ov);
    check(out_syndrome == x_os, x_ov ? "R6" : "R10", "out_syndrome", out_syndrome, x_os);
    check(out_data == x_od, x_ov ? x_tag : "R10", "out_data", out_data, x_od);
    check(out_err == x_oe, x_ov ? x_tag : "R10", "out_err", out_err, x_oe);
    check(out_uncorr == x_ou, x_ov ? x_tag : "R10", "out_uncorr", out_uncorr, x_ou);
    // drive the next vector
    wr_valid = wv;
    wr_data  = wd;
    rd_valid = rv;
    rd_code  = rc;
    x_ev = wv;
    if (wv) x_ec = m_encode(wd);
    x_ov = rv;
    if (rv) begin
      s = m_syn(rc);
      fixed = rc;
      if (s >= 1 && s <= 12) fixed[s-1] = ~fixed[s-1];
      x_os = s;
      x_od = m_data(fixed);
      x_oe = (s != 0);
      x_ou = (s > 12);
      x_tag = (s == 0) ? "R7" : ((s <= 12) ? "R8" : "R9");
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    done = 0;
    rst_n = 1'b0;
    wr_valid = 1'b0; wr_data = '0; rd_valid = 1'b0; rd_code = '0;
    x_ev = 0; x_ec = '0; x_ov = 0; x_od = '0; x_os = '0; x_oe = 0; x_ou = 0;
    x_tag = "R7";
    repeat (4) @(negedge clk);
    // R11: reset state while reset is held
    check(!enc_valid && enc_code == '0, "R11", "enc reset", {enc_valid, enc_code}, 0);
    check(!out_valid && out_data == '0 && out_syndrome == '0 && !out_err && !out_uncorr,
          "R11", "dec reset", {out_valid, out_data, out_syndrome, out_err, out_uncorr}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!enc_valid && !out_valid, "R11", "after release", {enc_valid, out_valid}, 0);

    // R1: codeword and syndrome widths
    check($bits(enc_code) == 12, "R1", "codeword width", $bits(enc_code), 12);
    check($bits(out_syndrome) == 4, "R1", "parity width", $bits(out_syndrome), 4);

    // R2: layout spot checks with literal codewords
    step(1, 8'h01, 0, '0);
    step(1, 8'h80, 0, '0);
    @(negedge clk);
    step(0, '0, 0, '0);
    check(enc_code == 12'h888, "R2", "d8 layout", enc_code, 12'h888);
    x_ec = 12'h888;
    // the d1 codeword was checked by step() against the model; check literal too
    check(m_encode(8'h01) == 12'h007, "R2", "d1 model", m_encode(8'h01), 12'h007);

    // R3/R4/R5: every payload, back to back with occasional idle cycles
    for (int d = 0; d < 256; d++) begin
      step(1, d[7:0], 0, '0);
      if (d % 7 == 3) step(0, 8'hA5, 0, '0);
    end
    step(0, '0, 0, '0);

    // R6/R7/R8: every payload clean and with each single flip
    for (int d = 0; d < 256; d++) begin
      for (int e = 0; e <= 12; e++) begin
        logic [11:0] w;
        w = m_encode(d[7:0]);
        if (e > 0) w[e-1] = ~w[e-1];
        step(0, '0, 1, w);
      end
      if (d % 5 == 2) step(0, '0, 0, 12'hFFF);
    end

    // R9 and miscorrection: every double flip of every payload
    for (int d = 0; d < 256; d++) begin
      for (int a = 0; a < 11; a++) begin
        for (int b = a + 1; b < 12; b++) begin
          logic [11:0] w;
          w = m_encode(d[7:0]);
          w[a] = ~w[a];
          w[b] = ~w[b];
          step(0, '0, 1, w);
        end
      end
    end
    step(0, '0, 0, '0);
    step(0, '0, 0, '0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule